// File: doc/BRIEF.md
# Serial Packet Receive Controller with Word Buffer

This block sits behind the line decoder and the bit destuffer of a serial packet receiver. It sequences a reception, packs the destuffed bits into 16-bit words and stores them in a 16-entry word buffer. It also records how many words arrived and latches the CRC verdict. Line decoding and the CRC arithmetic live outside. The block only sees the decoder's end-of-packet, idle and sync indications, the destuffer's bit and valid, and the two CRC checkers' match signals.

Software enables a reception by raising `run`. The controller waits until the line is known to be between packets (end-of-packet or idle). It then waits for a sync indication, enables the destuffer and collects bits. At end of packet it writes any partial word, puts the word count into the top buffer entry and samples the CRC result. The flags then hold until `run` drops. A host reads the buffer through `sel`. The upper nibble picks a word for the parallel output, and the lower nibble picks one bit of that word for the serial output.

States: OFF (run low, pointer preset, flags clear), WAIT_LINE (waiting for end-of-packet or idle), WAIT_SYNC (waiting for sync), RECV (collecting bits), FLUSH (partial word write), COUNT (count write and CRC sample) and DONE (hold until run drops). Transitions: OFF→WAIT_LINE when run is high. WAIT_LINE→WAIT_SYNC on end-of-packet or idle. WAIT_SYNC→RECV on sync. RECV→FLUSH on end-of-packet. FLUSH→COUNT and COUNT→DONE unconditionally. Any state→OFF when run is low.

Top module: `rxpkt_ctrl`

## Requirements
- R1: After run rises, destuff_en stays low until line_eop or line_idle has been seen and then sync_found has been seen. A sync_found before that, or bits offered before sync, have no effect on the buffer or on destuff_en.
- R2: While receiving, a bit is shifted in only in a cycle with rx_valid high. The first received bit ends up in bit 15 of its word. Every 16th bit completes a word, which is written to the current slot, and the slot advances by one.
- R3: The first slot written is start_addr when mode is 1 and slot 0 when mode is 0, sampled while the controller is in OFF.
- R4: At end of packet, if 1 to 15 bits of an unfinished word are held, they are written to the next slot right-aligned (the last received bit in bit 0) with the upper bits zero. If none are held, no extra slot is written.
- R5: After the packet ends, slot 15 receives the number of data words written in this reception, in its low 4 bits with the rest zero.
- R6: Slot 15 never receives data. A data write to slot 14 sets flag_overrun, and later complete or partial words of that reception are discarded.
- R7: Two cycles after the cycle in which line_eop is seen, flag_crc_good takes crc5_match if the reception held at most 24 bits, and crc16_match otherwise.
- R8: flag_stored rises with the first data word written in a reception.
- R9: flag_stored, flag_crc_good and flag_overrun hold until run is seen low, which clears them at the next edge. crc_clear is high exactly while the controller is in OFF.
- R10: rd_word shows slot sel[7:4] and rd_bit shows bit sel[3:0] of that slot (bit 0 being the LSB), combinationally.
- R11: Reset clears all slots and flags and puts the controller in OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Reception enable; low clears the flags |
| mode | input | 1 | 1: start writing at start_addr; 0: at slot 0 |
| start_addr | input | 4 | First slot when mode is 1 |
| line_eop | input | 1 | End-of-packet seen on the line |
| line_idle | input | 1 | Idle line seen |
| sync_found | input | 1 | Valid sync pattern seen |
| rx_bit | input | 1 | Destuffed data bit |
| rx_valid | input | 1 | rx_bit is valid this cycle |
| crc5_match | input | 1 | Short-packet CRC checker reports a match |
| crc16_match | input | 1 | Long-packet CRC checker reports a match |
| sel | input | 8 | Read select: [7:4] slot, [3:0] bit |
| destuff_en | output | 1 | Enables the destuffer during reception |
| crc_clear | output | 1 | Clears the CRC checkers while idle |
| rd_word | output | 16 | Selected slot |
| rd_bit | output | 1 | Selected bit of the selected slot |
| flag_stored | output | 1 | Data was stored in this reception |
| flag_crc_good | output | 1 | Latched CRC verdict |
| flag_overrun | output | 1 | Last data slot was written |

## Verification
The hardest condition to reach is an overrun with a tail still to come. The last data slot must be written in the middle of a packet, and more complete and partial words must then arrive to be discarded while the count write still lands in slot 15. The stimulus uses mode 1 with a start slot near the top of the buffer and sends a packet several words longer than the space left. A behavioural model keeps its own copy of the buffer and is compared on every cycle, and also in a full read through `sel` after each packet. The other packets cover the 24-bit CRC threshold, exact word multiples and valid gaps.

// File: rtl/rxpkt_pkg.sv
package rxpkt_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAIT_LINE,
        ST_WAIT_SYNC,
        ST_RECV,
        ST_FLUSH,
        ST_COUNT,
        ST_DONE
    } rx_state_t;

    typedef enum logic [1:0] {
        WK_NONE,
        WK_FULL,
        WK_PART,
        WK_COUNT
    } wr_kind_t;

endpackage

// File: rtl/rxpkt_shift.sv
module rxpkt_shift #(
    parameter int W     = 16,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             bit_in,
    input  logic             valid,
    output logic             word_done,
    output logic [W-1:0]     full_word,
    output logic [W-1:0]     part_word,
    output logic             has_partial,
    output logic [CNT_W-1:0] total_bits
);
    localparam int BIT_W = $clog2(W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(W - 1);

    logic [W-1:0]     sh_q;
    logic [BIT_W-1:0] cnt_q;
    logic             take;

    assign take        = en && valid;
    assign full_word   = {sh_q[W-2:0], bit_in};
    assign word_done   = take && (cnt_q == LAST_BIT);
    assign part_word   = sh_q;
    assign has_partial = (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q       <= '0;
            cnt_q      <= '0;
            total_bits <= '0;
        end else if (clr) begin
            sh_q       <= '0;
            cnt_q      <= '0;
            total_bits <= '0;
        end else if (take) begin
            if (word_done) begin
                sh_q  <= '0;
                cnt_q <= '0;
            end else begin
                sh_q  <= full_word;
                cnt_q <= cnt_q + 1'b1;
            end
            if (total_bits != '1) total_bits <= total_bits + 1'b1;
        end
    end

    // R2: nothing moves without a valid bit
    assert_shift_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !clr) |=> ($stable(cnt_q) && $stable(sh_q)));

endmodule

// File: rtl/rxpkt_buf.sv
module rxpkt_buf #(
    parameter int W      = 16,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [W-1:0]             wdata,
    input  logic [ADDR_W-1:0]        raddr,
    input  logic [$clog2(W)-1:0]     rbit,
    output logic [W-1:0]             rword,
    output logic                     rbit_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rword  = mem[raddr];
    assign rbit_q = rword[rbit];

endmodule

// File: rtl/rxpkt_fsm.sv
module rxpkt_fsm
    import rxpkt_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int CNT_W      = 6,
    parameter int SHORT_BITS = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              mode,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              line_eop,
    input  logic              line_idle,
    input  logic              sync_found,
    input  logic              word_done,
    input  logic              has_partial,
    input  logic [CNT_W-1:0]  total_bits,
    input  logic              crc5_match,
    input  logic              crc16_match,
    output logic              shift_en,
    output logic              shift_clr,
    output logic              destuff_en,
    output logic              crc_clear,
    output wr_kind_t          wr_kind,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] word_cnt,
    output logic              flag_stored,
    output logic              flag_crc_good,
    output logic              flag_overrun
);
    localparam logic [ADDR_W-1:0] LAST_SLOT = '1;
    localparam logic [ADDR_W-1:0] LAST_DATA = LAST_SLOT - 1'b1;
    localparam logic [CNT_W-1:0]  SHORT_LIM = CNT_W'(SHORT_BITS);

    rx_state_t         state_q, state_d;
    logic [ADDR_W-1:0] ptr_q;
    logic              data_wr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!run) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:       state_d = ST_WAIT_LINE;
                ST_WAIT_LINE: if (line_eop || line_idle) state_d = ST_WAIT_SYNC;
                ST_WAIT_SYNC: if (sync_found) state_d = ST_RECV;
                ST_RECV:      if (line_eop) state_d = ST_FLUSH;
                ST_FLUSH:     state_d = ST_COUNT;
                ST_COUNT:     state_d = ST_DONE;
                ST_DONE:      state_d = ST_DONE;
                default:      state_d = ST_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        shift_en   = 1'b0;
        shift_clr  = 1'b0;
        destuff_en = 1'b0;
        crc_clear  = 1'b0;
        wr_kind    = WK_NONE;
        unique case (state_q)
            ST_OFF: begin
                shift_clr = 1'b1;
                crc_clear = 1'b1;
            end
            ST_WAIT_LINE, ST_WAIT_SYNC, ST_DONE: ;
            ST_RECV: begin
                destuff_en = 1'b1;
                shift_en   = run && !line_eop;
                if (run && word_done && (ptr_q != LAST_SLOT)) wr_kind = WK_FULL;
            end
            ST_FLUSH: begin
                if (run && has_partial && (ptr_q != LAST_SLOT)) wr_kind = WK_PART;
            end
            ST_COUNT: begin
                if (run) wr_kind = WK_COUNT;
            end
            default: ;
        endcase
    end

    assign data_wr = (wr_kind == WK_FULL) || (wr_kind == WK_PART);
    assign wr_addr = (wr_kind == WK_COUNT) ? LAST_SLOT : ptr_q;

    // pointer, count and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q         <= '0;
            word_cnt      <= '0;
            flag_stored   <= 1'b0;
            flag_crc_good <= 1'b0;
            flag_overrun  <= 1'b0;
        end else begin
            if (state_q == ST_OFF) begin
                ptr_q    <= mode ? start_addr : '0;
                word_cnt <= '0;
            end else if (data_wr) begin
                ptr_q    <= ptr_q + 1'b1;
                word_cnt <= word_cnt + 1'b1;
            end
            if (!run) begin
                flag_stored   <= 1'b0;
                flag_crc_good <= 1'b0;
                flag_overrun  <= 1'b0;
            end else begin
                if (data_wr) begin
                    flag_stored <= 1'b1;
                    if (ptr_q == LAST_DATA) flag_overrun <= 1'b1;
                end
                if (state_q == ST_COUNT)
                    flag_crc_good <= (total_bits <= SHORT_LIM) ? crc5_match : crc16_match;
            end
        end
    end

    // R6: reserved slot never takes data
    assert_reserved_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |-> (wr_addr != LAST_SLOT));

    // R5: count always goes to the top slot
    assert_count_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind == WK_COUNT) |-> (wr_addr == LAST_SLOT));

    // R6: overrun rises only after a data write to the last data slot
    assert_overrun_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_overrun) |-> $past(data_wr && (wr_addr == LAST_DATA)));

    // R1: reception opens only after a sync indication
    assert_sync_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(destuff_en) |-> $past(sync_found && run));

    // R9: flags fall only after run was low
    assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(flag_stored) || $fell(flag_crc_good) || $fell(flag_overrun)) |-> !$past(run));

    // R8: stored flag rises only with a data write
    assert_stored_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_stored) |-> $past(data_wr));

endmodule

// File: rtl/rxpkt_ctrl.sv
module rxpkt_ctrl
    import rxpkt_pkg::*;
#(
    parameter int W          = 16,
    parameter int ADDR_W     = 4,
    parameter int CNT_W      = 6,
    parameter int SHORT_BITS = 24,
    parameter int BIT_W      = $clog2(W),
    parameter int SEL_W      = ADDR_W + BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              mode,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              line_eop,
    input  logic              line_idle,
    input  logic              sync_found,
    input  logic              rx_bit,
    input  logic              rx_valid,
    input  logic              crc5_match,
    input  logic              crc16_match,
    input  logic [SEL_W-1:0]  sel,
    output logic              destuff_en,
    output logic              crc_clear,
    output logic [W-1:0]      rd_word,
    output logic              rd_bit,
    output logic              flag_stored,
    output logic              flag_crc_good,
    output logic              flag_overrun
);
    logic              shift_en, shift_clr, word_done, has_partial;
    logic [W-1:0]      full_word, part_word, wr_data;
    logic [CNT_W-1:0]  total_bits;
    wr_kind_t          wr_kind;
    logic [ADDR_W-1:0] wr_addr, word_cnt;
    logic              wr_en;

    rxpkt_shift #(.W(W), .CNT_W(CNT_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (shift_clr),
        .en          (shift_en),
        .bit_in      (rx_bit),
        .valid       (rx_valid),
        .word_done   (word_done),
        .full_word   (full_word),
        .part_word   (part_word),
        .has_partial (has_partial),
        .total_bits  (total_bits)
    );

    rxpkt_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SHORT_BITS(SHORT_BITS)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (run),
        .mode          (mode),
        .start_addr    (start_addr),
        .line_eop      (line_eop),
        .line_idle     (line_idle),
        .sync_found    (sync_found),
        .word_done     (word_done),
        .has_partial   (has_partial),
        .total_bits    (total_bits),
        .crc5_match    (crc5_match),
        .crc16_match   (crc16_match),
        .shift_en      (shift_en),
        .shift_clr     (shift_clr),
        .destuff_en    (destuff_en),
        .crc_clear     (crc_clear),
        .wr_kind       (wr_kind),
        .wr_addr       (wr_addr),
        .word_cnt      (word_cnt),
        .flag_stored   (flag_stored),
        .flag_crc_good (flag_crc_good),
        .flag_overrun  (flag_overrun)
    );

    always_comb begin
        unique case (wr_kind)
            WK_FULL:  wr_data = full_word;
            WK_PART:  wr_data = part_word;
            WK_COUNT: wr_data = {{(W-ADDR_W){1'b0}}, word_cnt};
            default:  wr_data = '0;
        endcase
    end

    assign wr_en = (wr_kind != WK_NONE);

    rxpkt_buf #(.W(W), .ADDR_W(ADDR_W)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_en),
        .waddr  (wr_addr),
        .wdata  (wr_data),
        .raddr  (sel[SEL_W-1:BIT_W]),
        .rbit   (sel[BIT_W-1:0]),
        .rword  (rd_word),
        .rbit_q (rd_bit)
    );

    // R4: a partial word never carries bits above the received count
    assert_partial_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind == WK_PART) |-> (wr_data[W-1] == 1'b0));

endmodule

// File: tb/tb_rxpkt_ctrl.sv
module tb_rxpkt_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 0, mode = 0, line_eop = 0, line_idle = 0, sync_found = 0;
    logic        rx_bit = 0, rx_valid = 0, crc5_match = 0, crc16_match = 0;
    logic [3:0]  start_addr = '0;
    logic [7:0]  sel = '0;
    logic        destuff_en, crc_clear, rd_bit, flag_stored, flag_crc_good, flag_overrun;
    logic [15:0] rd_word;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    rxpkt_ctrl dut (
        .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .start_addr(start_addr),
        .line_eop(line_eop), .line_idle(line_idle), .sync_found(sync_found),
        .rx_bit(rx_bit), .rx_valid(rx_valid), .crc5_match(crc5_match),
        .crc16_match(crc16_match), .sel(sel), .destuff_en(destuff_en),
        .crc_clear(crc_clear), .rd_word(rd_word), .rd_bit(rd_bit),
        .flag_stored(flag_stored), .flag_crc_good(flag_crc_good),
        .flag_overrun(flag_overrun)
    );

    // behavioural reference
    int          phase;      // 0 off, 1 wait line, 2 wait sync, 3 recv, 4 flush, 5 count, 6 done
    int          m_ptr, m_cnt, m_total;
    bit          m_bits[$];
    logic [15:0] m_mem [16];
    bit          m_stored, m_crc, m_ovr;

    function automatic logic [15:0] fold_bits();
        logic [15:0] v = '0;
        foreach (m_bits[i]) v = {v[14:0], m_bits[i]};
        return v;
    endfunction

    task automatic m_write(logic [15:0] v);
        if (m_ptr != 15) begin
            m_mem[m_ptr] = v;
            m_cnt++;
            m_stored = 1;
            if (m_ptr == 14) m_ovr = 1;
            m_ptr++;
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase = 0; m_ptr = 0; m_cnt = 0; m_total = 0; m_bits.delete();
            m_stored = 0; m_crc = 0; m_ovr = 0;
            for (int i = 0; i < 16; i++) m_mem[i] = '0;
        end else if (!run) begin
            if (phase == 0) begin
                m_ptr = mode ? int'(start_addr) : 0;
                m_cnt = 0; m_total = 0; m_bits.delete();
            end
            phase = 0; m_stored = 0; m_crc = 0; m_ovr = 0;
        end else begin
            case (phase)
                0: begin
                    m_ptr = mode ? int'(start_addr) : 0;
                    m_cnt = 0; m_total = 0; m_bits.delete();
                    phase = 1;
                end
                1: if (line_eop || line_idle) phase = 2;
                2: if (sync_found) phase = 3;
                3: begin
                    if (line_eop) phase = 4;
                    else if (rx_valid) begin
                        m_bits.push_back(rx_bit);
                        m_total++;
                        if (m_bits.size() == 16) begin
                            m_write(fold_bits());
                            m_bits.delete();
                        end
                    end
                end
                4: begin
                    if (m_bits.size() != 0) m_write(fold_bits());
                    phase = 5;
                end
                5: begin
                    m_mem[15] = 16'(m_cnt);
                    m_crc = (m_total <= 24) ? crc5_match : crc16_match;
                    phase = 6;
                end
                default: ;
            endcase
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // cycle compare on registered outputs
    always @(negedge clk) begin
        check(destuff_en == (phase == 3), "R1", "destuff_en", destuff_en, phase == 3);
        check(crc_clear == (phase == 0), "R9", "crc_clear", crc_clear, phase == 0);
        check(flag_stored == m_stored, "R8", "flag_stored", flag_stored, m_stored);
        check(flag_crc_good == m_crc, "R7", "flag_crc_good", flag_crc_good, m_crc);
        check(flag_overrun == m_ovr, "R6", "flag_overrun", flag_overrun, m_ovr);
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    // R10 read port, covering stored words (R2 R3 R4 R5 R6 R11)
    task automatic read_all();
        for (int a = 0; a < 16; a++) begin
            sel = {4'(a), 4'(a + 3)};
            #1;
            check(rd_word == m_mem[a], "R10", $sformatf("slot %0d word (R2 R4 R5 R6)", a),
                  rd_word, m_mem[a]);
            check(rd_bit == m_mem[a][(a + 3) % 16], "R10", "serial bit", rd_bit,
                  m_mem[a][(a + 3) % 16]);
        end
    endtask

    task automatic packet(bit md, logic [3:0] sa, int nbits, bit c5, bit c16, int seed);
        mode = md; start_addr = sa;
        step(2);
        run = 1;
        step(2);
        sync_found = 1; step(); sync_found = 0;      // R1: early sync ignored
        rx_valid = 1; rx_bit = 1; step(2); rx_valid = 0;
        if (seed % 2 == 0) line_idle = 1; else line_eop = 1;
        step(); line_idle = 0; line_eop = 0;
        rx_valid = 1; rx_bit = 1; step(3); rx_valid = 0;  // R1: bits before sync ignored
        step();
        sync_found = 1; step(); sync_found = 0;
        for (int i = 0; i < nbits; i++) begin
            rx_bit = 1'(((i * 5 + seed) % 7) < 3);
            rx_valid = 1;
            step();
            if (i % 5 == 4) begin rx_valid = 0; rx_bit = ~rx_bit; step(); end  // R2 gaps
        end
        rx_valid = 0;
        crc5_match = c5; crc16_match = c16;
        line_eop = 1; step(); line_eop = 0;
        step(4);
        read_all();
        run = 0;
        step(3);
        crc5_match = 0; crc16_match = 0;
        read_all();
    endtask

    initial begin
        step(3);
        read_all();                      // R11 reset contents
        rst_n = 1;
        step(2);
        packet(1'b0, 4'd0, 24, 1'b1, 1'b0, 1);   // R7 short: crc5 used, R4 partial
        packet(1'b1, 4'd3, 40, 1'b1, 1'b0, 2);   // R3 start slot, R7 long: crc16
        packet(1'b0, 4'd9, 32, 1'b0, 1'b1, 3);   // R4 exact words, no partial
        packet(1'b1, 4'd12, 70, 1'b0, 1'b1, 4);  // R6 overrun with discarded tail
        packet(1'b1, 4'd14, 9, 1'b1, 1'b1, 5);   // R6 partial into last data slot
        packet(1'b1, 4'd15, 20, 1'b1, 1'b0, 6);  // R6 start at reserved slot
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule